// File: doc/BRIEF.md
# Configurable LCD Pixel Unpacker

This block splits 32-bit frame-buffer words into single display pixels. A word arrives on a valid/ready input stream. It is held until every pixel it contains has left through a valid/ready output stream. Each output beat is either a palette index (with `px_indexed` high) or an 8-bit-per-channel direct colour.

The pixel depth, the red/blue channel order, the byte order and the pixel order inside a word are static configuration inputs. Software changes them only while the block is idle. A separate 2-bit format input lets board logic choose how 16-bit data is read. It selects between 5551, 565, and 565 with red and blue forced to swap.

Alongside the stream, the block computes the number of source bytes that one display line occupies, for the configured depth and column count.

Top module: `pixel_unpacker`

## Requirements
- R1: The depth code selects the bits per pixel: 0=1, 1=2, 2=4, 3=8, 4=16, 5=32, 6=16 (565), 7=12 (held in a 16-bit slot). Each accepted word yields exactly 32/bits pixel beats, for example 32 at code 0 and 2 at codes 4, 6 and 7.
- R2: `line_bytes` is columns/8, /4 and /2 for codes 0, 1 and 2. It equals columns for code 3, columns×2 for codes 4, 6 and 7, and columns×4 for code 5.
- R3: With both order flags clear, pixel k of a word is taken from bits [k*bits +: bits], least-significant pixel first.
- R4: With `pix_msb_first` set and `byte_swap` clear, the most-significant pixel of the word is emitted first.
- R5: With `byte_swap` set, byte 3 of the word becomes byte 0 (and 2 becomes 1) before unpacking in the R3 order, whatever the value of `pix_msb_first`.
- R6: Codes 0 to 3 raise `px_indexed`. `px_index` then carries the pixel value zero-extended and `px_rgb` is zero. For direct colour `px_indexed` is low and `px_index` is zero.
- R7: Code 5 takes the low channel from bits [7:0], green from [15:8] and the high channel from [23:16], and ignores bits [31:24]. `px_rgb` is {red, green, blue}, with red in [23:16]. With `rb_swap` clear the low channel is red; with it set the low channel is blue.
- R8: Code 6, and code 4 with `fmt16` equal to 0 or 2, decode 565. The low channel is [4:0], green is [10:5] and the high channel is [15:11]. Channels are widened by repeating their top bits, so 5-bit v becomes {v, v[4:2]} and 6-bit v becomes {v, v[5:4]}. `rb_swap` works as in R7.
- R9: Code 4 with `fmt16` = 1 decodes 5551. The channels are [4:0], [9:5] and [14:10], all 5-bit, and bit 15 is ignored. `rb_swap` works as in R7.
- R10: Code 4 with `fmt16` = 3 decodes 565 with the low channel placed as blue, whatever the value of `rb_swap`.
- R11: Code 7 decodes 4-bit channels at [3:0], [7:4] and [11:8], widened to {v, v}, and ignores bits [15:12]. `rb_swap` works as in R7.
- R12: After reset `px_valid` is 0 and `wd_ready` is 1. `wd_ready` is high only when no pixel is pending, or when the last pixel of the held word is being accepted. While `px_valid` is high and `px_ready` is low, the output beat stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth | input | 3 | Depth code (R1) |
| rb_swap | input | 1 | Swap red and blue channels of direct colour |
| byte_swap | input | 1 | Reverse the bytes of each word before unpacking |
| pix_msb_first | input | 1 | Emit the most-significant pixel first |
| fmt16 | input | 2 | Reading of 16-bit data at depth code 4 |
| cols | input | COL_W | Display columns per line |
| line_bytes | output | COL_W+2 | Source bytes per line |
| wd_valid | input | 1 | Input word valid |
| wd_ready | output | 1 | Input word accepted |
| wd_data | input | 32 | Frame-buffer word |
| px_valid | output | 1 | Pixel beat valid |
| px_ready | input | 1 | Downstream accepts pixel |
| px_indexed | output | 1 | Beat is a palette index |
| px_index | output | 8 | Palette index |
| px_rgb | output | 24 | Direct colour {R,G,B} |

## Verification
On every cycle, the assertions check how the word holder behaves around the handshake. They check that a stalled beat keeps its word and slot, that a loaded word starts at slot 0, and that slots advance by one per accepted pixel. They also check that indexed and direct beats never carry stray data in the other field.

The bench alone can show that the correct bits reach the correct channel, in the correct order, for each depth code, format value, swap setting and order flag. It does this by sweeping every configuration with pseudo-random words under irregular back-pressure. It also sweeps column counts against the line-length arithmetic.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
    localparam int WORD_W  = 32;
    localparam int SLOT_W  = $clog2(WORD_W);
    localparam int NBYTES  = WORD_W / 8;

    typedef enum logic [2:0] {
        DEP_1   = 3'd0,
        DEP_2   = 3'd1,
        DEP_4   = 3'd2,
        DEP_8   = 3'd3,
        DEP_16  = 3'd4,
        DEP_32  = 3'd5,
        DEP_565 = 3'd6,
        DEP_12  = 3'd7
    } depth_e;

    typedef enum logic [2:0] {
        FMT_IDX,
        FMT_888,
        FMT_565,
        FMT_5551,
        FMT_444
    } fmt_e;

    // log2 of the container width a depth code occupies in a word
    function automatic logic [2:0] slot_lg2(input logic [2:0] d);
        logic [2:0] r;
        if (d <= 3'd5) r = d;
        else           r = 3'd4;
        return r;
    endfunction
endpackage

// File: rtl/unpk_line_calc.sv
module unpk_line_calc #(
    parameter int COL_W = 12
) (
    input  logic [2:0]       depth,
    input  logic [COL_W-1:0] cols,
    output logic [COL_W+1:0] line_bytes
);
    import unpk_pkg::*;
    localparam int LB_W = COL_W + 2;

    logic [LB_W-1:0] cols_x;
    assign cols_x = LB_W'(cols);

    always_comb begin
        unique case (depth_e'(depth))
            DEP_1:   line_bytes = cols_x >> 3;
            DEP_2:   line_bytes = cols_x >> 2;
            DEP_4:   line_bytes = cols_x >> 1;
            DEP_8:   line_bytes = cols_x;
            DEP_32:  line_bytes = cols_x << 2;
            default: line_bytes = cols_x << 1;
        endcase
    end
endmodule

// File: rtl/unpk_word_buf.sv
module unpk_word_buf
    import unpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        lg2,
    input  logic              byte_swap,
    input  logic              wd_valid,
    input  logic [WORD_W-1:0] wd_data,
    output logic              wd_ready,
    input  logic              px_ready,
    output logic              hold_valid,
    output logic [WORD_W-1:0] hold_word,
    output logic [SLOT_W-1:0] hold_slot,
    output logic [SLOT_W-1:0] last_slot
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
        logic [SLOT_W-1:0] slot;
    } st_t;

    st_t st_d, st_q;
    logic [WORD_W-1:0] swapped;
    logic [SLOT_W:0]   ppw;
    logic              last, take, drain;

    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign swapped[8*b +: 8] = wd_data[WORD_W-8-8*b +: 8];
    end

    assign ppw       = (SLOT_W+1)'(WORD_W) >> lg2;
    assign last_slot = SLOT_W'(ppw - 1'b1);
    assign last      = (st_q.slot == last_slot);
    assign wd_ready  = !st_q.valid || (px_ready && last);
    assign take      = wd_valid && wd_ready;
    assign drain     = st_q.valid && px_ready;

    always_comb begin
        st_d = st_q;
        if (drain) begin
            if (last) begin
                st_d.valid = 1'b0;
                st_d.slot  = '0;
            end else begin
                st_d.slot  = st_q.slot + 1'b1;
            end
        end
        if (take) begin
            st_d.valid = 1'b1;
            st_d.word  = byte_swap ? swapped : wd_data;
            st_d.slot  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_valid = st_q.valid;
    assign hold_word  = st_q.word;
    assign hold_slot  = st_q.slot;

    a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !px_ready) |=> (st_q.valid && $stable(st_q.word) && $stable(st_q.slot)));

    a_r12_load_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && wd_ready) |=> (st_q.valid && st_q.slot == '0));

    a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && px_ready && !last && !wd_valid) |=> (st_q.slot == $past(st_q.slot) + 1'b1));

    a_r12_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && px_ready && last && !wd_valid) |=> !st_q.valid);
endmodule

// File: rtl/unpk_pix_decode.sv
module unpk_pix_decode
    import unpk_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W-1:0] last_slot,
    input  logic [2:0]        lg2,
    input  logic [2:0]        depth,
    input  logic              msb_first,
    input  logic              rb_swap,
    input  logic [1:0]        fmt16,
    output logic              indexed,
    output logic [7:0]        index,
    output logic [23:0]       rgb
);
    localparam int SH_W = SLOT_W + 1;

    logic [SLOT_W-1:0] pos;
    logic [SH_W-1:0]   shamt;
    logic [SH_W-1:0]   nbits;
    logic [WORD_W-1:0] mask, raw;
    fmt_e              fmt;
    logic              swap;
    logic [7:0]        lo, mid, hi;

    assign pos   = msb_first ? (last_slot - slot) : slot;
    assign shamt = {1'b0, pos} << lg2;
    assign nbits = SH_W'(1) << lg2;
    assign mask  = (nbits >= SH_W'(WORD_W)) ? '1 : ((WORD_W'(1) << nbits) - 1'b1);
    assign raw   = (word >> shamt) & mask;

    always_comb begin
        swap = rb_swap;
        unique case (depth_e'(depth))
            DEP_1, DEP_2, DEP_4, DEP_8: fmt = FMT_IDX;
            DEP_32:  fmt = FMT_888;
            DEP_565: fmt = FMT_565;
            DEP_12:  fmt = FMT_444;
            default: begin
                unique case (fmt16)
                    2'd1:    fmt = FMT_5551;
                    2'd3:    begin fmt = FMT_565; swap = 1'b1; end
                    default: fmt = FMT_565;
                endcase
            end
        endcase
    end

    always_comb begin
        lo  = '0;
        mid = '0;
        hi  = '0;
        unique case (fmt)
            FMT_888: begin
                lo = raw[7:0]; mid = raw[15:8]; hi = raw[23:16];
            end
            FMT_565: begin
                lo  = {raw[4:0],   raw[4:2]};
                mid = {raw[10:5],  raw[10:9]};
                hi  = {raw[15:11], raw[15:13]};
            end
            FMT_5551: begin
                lo  = {raw[4:0],   raw[4:2]};
                mid = {raw[9:5],   raw[9:7]};
                hi  = {raw[14:10], raw[14:12]};
            end
            FMT_444: begin
                lo  = {raw[3:0],  raw[3:0]};
                mid = {raw[7:4],  raw[7:4]};
                hi  = {raw[11:8], raw[11:8]};
            end
            default: ;
        endcase
    end

    assign indexed = (fmt == FMT_IDX);
    assign index   = indexed ? raw[7:0] : 8'd0;
    assign rgb     = indexed ? 24'd0 : (swap ? {hi, mid, lo} : {lo, mid, hi});

    always_comb begin
        if (indexed) begin
            a_r6_idx_no_rgb: assert (rgb == 24'd0);
            a_r6_idx_fits: assert ((16'(index) >> nbits) == 16'd0);
        end else begin
            a_r6_direct_no_idx: assert (index == 8'd0);
        end
    end
endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
    import unpk_pkg::*;
#(
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       depth,
    input  logic             rb_swap,
    input  logic             byte_swap,
    input  logic             pix_msb_first,
    input  logic [1:0]       fmt16,
    input  logic [COL_W-1:0] cols,
    output logic [COL_W+1:0] line_bytes,
    input  logic             wd_valid,
    output logic             wd_ready,
    input  logic [31:0]      wd_data,
    output logic             px_valid,
    input  logic             px_ready,
    output logic             px_indexed,
    output logic [7:0]       px_index,
    output logic [23:0]      px_rgb
);
    logic [2:0]        lg2;
    logic              msb_eff;
    logic              hold_valid;
    logic [WORD_W-1:0] hold_word;
    logic [SLOT_W-1:0] hold_slot, last_slot;

    assign lg2     = slot_lg2(depth);
    assign msb_eff = pix_msb_first && !byte_swap;

    unpk_line_calc #(.COL_W(COL_W)) u_line (
        .depth      (depth),
        .cols       (cols),
        .line_bytes (line_bytes)
    );

    unpk_word_buf u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .lg2        (lg2),
        .byte_swap  (byte_swap),
        .wd_valid   (wd_valid),
        .wd_data    (wd_data),
        .wd_ready   (wd_ready),
        .px_ready   (px_ready),
        .hold_valid (hold_valid),
        .hold_word  (hold_word),
        .hold_slot  (hold_slot),
        .last_slot  (last_slot)
    );

    unpk_pix_decode u_dec (
        .word      (hold_word),
        .slot      (hold_slot),
        .last_slot (last_slot),
        .lg2       (lg2),
        .depth     (depth),
        .msb_first (msb_eff),
        .rb_swap   (rb_swap),
        .fmt16     (fmt16),
        .indexed   (px_indexed),
        .index     (px_index),
        .rgb       (px_rgb)
    );

    assign px_valid = hold_valid;
endmodule

// File: tb/pixel_unpacker_bench.sv
`timescale 1ns/1ps
module pixel_unpacker_bench;
    localparam int COL_W = 12;
    localparam int NW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       depth = '0;
    logic             rb_swap = 1'b0, byte_swap = 1'b0, pix_msb_first = 1'b0;
    logic [1:0]       fmt16 = '0;
    logic [COL_W-1:0] cols = '0;
    logic [COL_W+1:0] line_bytes;
    logic             wd_valid = 1'b0, wd_ready;
    logic [31:0]      wd_data = '0;
    logic             px_valid, px_ready = 1'b0, px_indexed;
    logic [7:0]       px_index;
    logic [23:0]      px_rgb;

    int checks = 0;
    int fails  = 0;
    logic [31:0] seed = 32'h1234_5677;

    always #4 clk = ~clk;

    pixel_unpacker #(.COL_W(COL_W)) u_pixel_unpacker (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bits_of(input int d);
        int t[8] = '{1, 2, 4, 8, 16, 32, 16, 16};
        return t[d];
    endfunction

    function automatic int fld(input logic [31:0] v, input int lsb, input int n);
        return int'((v >> lsb) & ((32'd1 << n) - 1));
    endfunction

    function automatic int widen(input int v, input int n);
        return ((v << (8 - n)) | (v >> (2 * n - 8))) & 255;
    endfunction

    // expected {indexed, index, rgb}
    function automatic logic [32:0] expect_pix(input logic [31:0] w, input int k, input int d,
                                               input bit bgr, input bit bb, input bit bp, input int mux);
        logic [31:0] w2, raw;
        int bits, ppw, p, lo, mid, hi;
        bit sw;
        bits = bits_of(d);
        ppw  = 32 / bits;
        w2 = bb ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        p  = (!bb && bp) ? (ppw - 1 - k) : k;
        raw = '0;
        for (int i = 0; i < bits; i++) raw[i] = w2[p * bits + i];
        if (d <= 3) return {1'b1, raw[7:0], 24'd0};
        sw = bgr;
        if (d == 5) begin
            lo = fld(raw, 0, 8); mid = fld(raw, 8, 8); hi = fld(raw, 16, 8);
        end else if (d == 7) begin
            lo = widen(fld(raw, 0, 4), 4); mid = widen(fld(raw, 4, 4), 4); hi = widen(fld(raw, 8, 4), 4);
        end else if (d == 4 && mux == 1) begin
            lo = widen(fld(raw, 0, 5), 5); mid = widen(fld(raw, 5, 5), 5); hi = widen(fld(raw, 10, 5), 5);
        end else begin
            if (d == 4 && mux == 3) sw = 1'b1;
            lo = widen(fld(raw, 0, 5), 5); mid = widen(fld(raw, 5, 6), 6); hi = widen(fld(raw, 11, 5), 5);
        end
        if (sw) return {1'b0, 8'd0, 8'(hi), 8'(mid), 8'(lo)};
        return {1'b0, 8'd0, 8'(lo), 8'(mid), 8'(hi)};
    endfunction

    function automatic string tag_of(input int d, input bit bb, input bit bp, input int mux);
        string o, f;
        o = bb ? "R5" : (bp ? "R4" : "R3");
        if (d <= 3)      f = "R6";
        else if (d == 5) f = "R7";
        else if (d == 6) f = "R8";
        else if (d == 7) f = "R11";
        else if (mux == 1) f = "R9";
        else if (mux == 3) f = "R10";
        else f = "R8";
        return {o, "/", f};
    endfunction

    task automatic run_cfg(input int d, input bit bgr, input bit bb, input bit bp, input int mux);
        logic [31:0] w[NW];
        logic [32:0] e, prev;
        int ppw, prod, cons_w, cons_k, cyc, seen;
        bit stalled;
        string tg;
        @(negedge clk);
        depth = 3'(d); rb_swap = bgr; byte_swap = bb; pix_msb_first = bp; fmt16 = 2'(mux);
        for (int i = 0; i < NW; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            w[i] = seed ^ (seed >> 13);
        end
        ppw = 32 / bits_of(d);
        prod = 0; cons_w = 0; cons_k = 0; cyc = 0; seen = 0; stalled = 0; prev = '0;
        tg = tag_of(d, bb, bp, mux);
        while (cons_w < NW && cyc < 2000) begin
            if (cyc > 0) @(negedge clk);
            px_ready = ((cyc % 3) != 1);
            wd_valid = (prod < NW) && ((cyc % 5) != 2);
            wd_data  = wd_valid ? w[prod] : 32'hDEAD_BEEF;
            #1;
            if (stalled)
                chk(px_valid && {px_indexed, px_index, px_rgb} == prev, "R12 stall hold",
                    64'({px_indexed, px_index, px_rgb}), 64'(prev));
            if (wd_ready)
                chk(!px_valid || (px_ready && cons_k == ppw - 1), "R12 ready gating",
                    64'(cons_k), 64'(ppw - 1));
            if (px_valid && px_ready) begin
                e = expect_pix(w[cons_w], cons_k, d, bgr, bb, bp, mux);
                chk({px_indexed, px_index, px_rgb} == e, tg,
                    64'({px_indexed, px_index, px_rgb}), 64'(e));
                seen++;
                if (cons_k == ppw - 1) begin cons_k = 0; cons_w++; end
                else cons_k++;
            end
            stalled = px_valid && !px_ready;
            prev = {px_indexed, px_index, px_rgb};
            if (wd_valid && wd_ready) prod++;
            cyc++;
        end
        @(negedge clk);
        wd_valid = 1'b0; px_ready = 1'b1;
        #1;
        chk(seen == NW * ppw && !px_valid, "R1 pixel count", 64'(seen), 64'(NW * ppw));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(px_valid == 1'b0, "R12 reset valid", 64'(px_valid), 64'd0);
        chk(wd_ready == 1'b1, "R12 reset ready", 64'(wd_ready), 64'd1);

        // R2 line length sweep
        for (int d = 0; d < 8; d++) begin
            for (int c = 0; c < 4096; c += 37) begin
                int expb;
                depth = 3'(d); cols = COL_W'(c);
                #1;
                case (d)
                    0: expb = c / 8;
                    1: expb = c / 4;
                    2: expb = c / 2;
                    3: expb = c;
                    5: expb = c * 4;
                    default: expb = c * 2;
                endcase
                chk(int'(line_bytes) == expb, "R2 line bytes", 64'(line_bytes), 64'(expb));
            end
        end

        // full configuration sweep
        for (int d = 0; d < 8; d++) begin
            for (int mux = 0; mux < ((d == 4) ? 4 : 1); mux++) begin
                for (int bgr = 0; bgr < 2; bgr++) begin
                    for (int ord = 0; ord < 4; ord++) begin
                        run_cfg(d, bit'(bgr), bit'(ord[1]), bit'(ord[0]), mux);
                    end
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule